// File: doc/BRIEF.md
# Physical-to-Virtual Reverse Map Table

This block sits beside a cache whose lines are tagged with virtual addresses. For each 4 KB physical page that has lines in the cache, it records the virtual page now tagging those lines, the access permission that came with the first fill, and a 64-bit line-presence vector with one bit per 64-byte line. Every miss response from the translation fabric passes through the table before the cache allocates. The table reports one of three outcomes. The page is new and was entered. The page was known and the line's bit is now set. Or the line is already cached under another virtual address (a synonym). In the synonym case the cache must restart the access with the recorded virtual address and must not allocate.

Coherence traffic arrives with physical line addresses. The table answers with hit or miss and the virtual line address, so any probe for a line that is not cached is filtered out here. When the cache drops a line it sends a clear message, and an entry whose vector becomes empty is freed. The table is set associative and indexed by the low physical page number bits. When a new page has to displace a resident one, the displaced page's virtual page and presence vector go out as a back-invalidate request. New fills are held off until the cache acknowledges that request.

Top module: `p2v_reverse_map`

## Requirements
- R1: After reset the table is empty, `res_valid`, `coh_valid` and `inv_valid` are low, and `fill_ready` is high.
- R2: An accepted fill (`fill_valid` and `fill_ready`) whose physical page has no entry allocates one with the fill's virtual page and permission and sets the line's bit. One cycle later it reports `res_kind` = 0 (new) with `res_vaddr` equal to the fill's virtual address.
- R3: An accepted fill whose page has an entry with the line bit clear sets that bit. One cycle later it reports `res_kind` = 1 (line added) with `res_vaddr` equal to the fill's virtual address.
- R4: An accepted fill whose page has an entry with the line bit already set reports `res_kind` = 2 (synonym) one cycle later. `res_vaddr` is the recorded virtual page followed by the fill's 12 page-offset bits, and `res_perm` is the recorded permission. The table is left unchanged.
- R5: A coherence lookup (`coh_req`) gives `coh_valid` one cycle later. `coh_hit` is high only if the page has an entry and the line bit (physical address bits 11:6) is set, and then `coh_vaddr` is the recorded virtual page followed by the request's page-offset bits.
- R6: Allocating into a set with all ways valid replaces a victim chosen round robin per set, starting at way 0. One cycle later `inv_valid` rises carrying the victim's virtual page and full presence vector, and it holds them steady until `inv_ack`.
- R7: While `inv_valid` is high, `fill_ready` is low and any fill offered is ignored: it gives no result and does not change the table. `inv_ack` drops `inv_valid` on the next cycle.
- R8: A clear message (`clr_valid`) for a physical line clears that line's bit. When the vector becomes empty the entry is freed, so a later lookup misses and a later fill to that page is new.
- R9: In a cycle with `clr_valid` high, `fill_ready` is low and an offered fill is ignored.
- R10: The set index is physical page number bits [3:0] (address bits 15:12). Pages that share a set but differ in higher bits occupy different ways without evicting one another until all ways are in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Miss response offered |
| fill_ready | output | 1 | Table accepts a fill this cycle |
| fill_vaddr | input | VA_W | Virtual address of the miss |
| fill_paddr | input | PA_W | Physical address returned by translation |
| fill_perm | input | PERM_W | Permission returned by translation |
| res_valid | output | 1 | Fill outcome valid |
| res_kind | output | 2 | 0 new page, 1 line added, 2 synonym |
| res_vaddr | output | VA_W | Virtual address the cache should use |
| res_perm | output | PERM_W | Permission for that address |
| coh_req | input | 1 | Coherence lookup request |
| coh_paddr | input | PA_W | Physical line address of the probe |
| coh_valid | output | 1 | Lookup answer valid |
| coh_hit | output | 1 | Line is present in the cache |
| coh_vaddr | output | VA_W | Virtual address of the present line |
| clr_valid | input | 1 | Cache dropped a line |
| clr_paddr | input | PA_W | Physical address of the dropped line |
| inv_valid | output | 1 | Back-invalidate request pending |
| inv_vpn | output | VA_W-12 | Virtual page to invalidate |
| inv_lines | output | 64 | Lines of that page to invalidate |
| inv_ack | input | 1 | Cache finished the back-invalidate |

## Verification
The bench uses the default build: 24-bit physical and virtual addresses, 2-bit permission, 16 sets of 4 ways. With these values every one of the 64 lines of a page can be swept for new, line-added and synonym outcomes and for coherence hits and misses. Five and then six pages can be aimed at a single set, which walks the round-robin victim choice through its first two ways and fills the whole set. Each expected address is built arithmetically from page and line numbers.

// File: rtl/p2v_reverse_map.sv
module p2v_reverse_map #(
  parameter int PA_W   = 24,
  parameter int VA_W   = 24,
  parameter int PERM_W = 2,
  parameter int SETS   = 16,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VA_W-1:0]   fill_vaddr,
  input  logic [PA_W-1:0]   fill_paddr,
  input  logic [PERM_W-1:0] fill_perm,
  output logic              res_valid,
  output logic [1:0]        res_kind,
  output logic [VA_W-1:0]   res_vaddr,
  output logic [PERM_W-1:0] res_perm,
  input  logic              coh_req,
  input  logic [PA_W-1:0]   coh_paddr,
  output logic              coh_valid,
  output logic              coh_hit,
  output logic [VA_W-1:0]   coh_vaddr,
  input  logic              clr_valid,
  input  logic [PA_W-1:0]   clr_paddr,
  output logic              inv_valid,
  output logic [VA_W-13:0]  inv_vpn,
  output logic [63:0]       inv_lines,
  input  logic              inv_ack
);
  localparam int PG    = 12;
  localparam int LN    = 6;
  localparam int LINES = 1 << (PG - LN);
  localparam int VPN_W = VA_W - PG;
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = PA_W - PG - IDX_W;
  localparam int N     = SETS * WAYS;
  localparam int E_W   = IDX_W + WAY_W;

  localparam logic [1:0] K_NEW = 2'd0;
  localparam logic [1:0] K_ADD = 2'd1;
  localparam logic [1:0] K_SYN = 2'd2;

  logic             v_q    [N];
  logic [TAG_W-1:0] tag_q  [N];
  logic [VPN_W-1:0] vpn_q  [N];
  logic [PERM_W-1:0] perm_q[N];
  logic [LINES-1:0] vec_q  [N];
  logic [WAY_W-1:0] rr_q   [SETS];

  function automatic logic [WAY_W:0] find(input logic [PA_W-1:0] pa);
    logic [WAY_W:0] r;
    r = '0;
    for (int w = 0; w < WAYS; w++)
      if (v_q[{pa[PG +: IDX_W], WAY_W'(w)}] &&
          tag_q[{pa[PG +: IDX_W], WAY_W'(w)}] == pa[PG+IDX_W +: TAG_W])
        r = {1'b1, WAY_W'(w)};
    return r;
  endfunction

  logic [WAY_W:0] f_m, c_m, k_m;
  assign f_m = find(fill_paddr);
  assign c_m = find(coh_paddr);
  assign k_m = find(clr_paddr);

  logic [IDX_W-1:0] f_set;
  logic [E_W-1:0]   f_e, c_e, k_e, a_e;
  logic [LN-1:0]    f_line, c_line, k_line;
  assign f_set  = fill_paddr[PG +: IDX_W];
  assign f_e    = {f_set, f_m[WAY_W-1:0]};
  assign c_e    = {coh_paddr[PG +: IDX_W], c_m[WAY_W-1:0]};
  assign k_e    = {clr_paddr[PG +: IDX_W], k_m[WAY_W-1:0]};
  assign f_line = fill_paddr[LN +: LN];
  assign c_line = coh_paddr[LN +: LN];
  assign k_line = clr_paddr[LN +: LN];

  logic             f_free;
  logic [WAY_W-1:0] f_fway;
  always_comb begin
    f_free = 1'b0;
    f_fway = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!v_q[{f_set, WAY_W'(w)}]) begin
        f_free = 1'b1;
        f_fway = WAY_W'(w);
      end
  end

  assign a_e = {f_set, f_free ? f_fway : rr_q[f_set]};

  logic [LINES-1:0] k_rem, f_bit;
  assign k_rem = vec_q[k_e] & ~(LINES'(1) << k_line);
  assign f_bit = LINES'(1) << f_line;

  assign fill_ready = !inv_valid && !clr_valid;
  logic fill_go;
  assign fill_go = fill_valid && fill_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        v_q[i] <= 1'b0; tag_q[i] <= '0; vpn_q[i] <= '0; perm_q[i] <= '0; vec_q[i] <= '0;
      end
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
      res_valid <= 1'b0; res_kind <= K_NEW; res_vaddr <= '0; res_perm <= '0;
      coh_valid <= 1'b0; coh_hit <= 1'b0; coh_vaddr <= '0;
      inv_valid <= 1'b0; inv_vpn <= '0; inv_lines <= '0;
    end else begin
      coh_valid <= coh_req;
      coh_hit   <= coh_req && c_m[WAY_W] && vec_q[c_e][c_line];
      coh_vaddr <= {vpn_q[c_e], coh_paddr[PG-1:0]};
      res_valid <= fill_go;
      if (inv_valid && inv_ack) inv_valid <= 1'b0;
      if (clr_valid && k_m[WAY_W]) begin
        vec_q[k_e] <= k_rem;
        if (k_rem == '0) v_q[k_e] <= 1'b0;
      end else if (fill_go) begin
        if (f_m[WAY_W] && vec_q[f_e][f_line]) begin
          res_kind  <= K_SYN;
          res_vaddr <= {vpn_q[f_e], fill_paddr[PG-1:0]};
          res_perm  <= perm_q[f_e];
        end else begin
          res_vaddr <= fill_vaddr;
          res_perm  <= fill_perm;
          if (f_m[WAY_W]) begin
            res_kind     <= K_ADD;
            vec_q[f_e]   <= vec_q[f_e] | f_bit;
          end else begin
            res_kind     <= K_NEW;
            v_q[a_e]     <= 1'b1;
            tag_q[a_e]   <= fill_paddr[PG+IDX_W +: TAG_W];
            vpn_q[a_e]   <= fill_vaddr[VA_W-1:PG];
            perm_q[a_e]  <= fill_perm;
            vec_q[a_e]   <= f_bit;
            if (!f_free) begin
              rr_q[f_set] <= rr_q[f_set] + 1'b1;
              inv_valid   <= 1'b1;
              inv_vpn     <= vpn_q[a_e];
              inv_lines   <= vec_q[a_e];
            end
          end
        end
      end
    end
  end

  assert_fill_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && fill_ready |=> res_valid);
  assert_syn_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind == K_SYN |-> res_vaddr[PG-1:0] == $past(fill_paddr[PG-1:0]));
  assert_coh_answer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    coh_req |=> coh_valid);
  assert_inv_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ack |=> inv_valid && $stable(inv_vpn) && $stable(inv_lines));
  assert_inv_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> inv_lines != '0);
  assert_blocked_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !fill_ready |=> !res_valid);
  assert_ack_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && inv_ack |=> !inv_valid);
  assert_kind_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_kind != 2'd3);
endmodule

// File: tb/test_p2v_reverse_map.sv
module test_p2v_reverse_map;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fill_valid = 0, fill_ready;
  logic [23:0] fill_vaddr = 0, fill_paddr = 0;
  logic [1:0] fill_perm = 0;
  logic res_valid; logic [1:0] res_kind; logic [23:0] res_vaddr; logic [1:0] res_perm;
  logic coh_req = 0; logic [23:0] coh_paddr = 0;
  logic coh_valid, coh_hit; logic [23:0] coh_vaddr;
  logic clr_valid = 0; logic [23:0] clr_paddr = 0;
  logic inv_valid; logic [11:0] inv_vpn; logic [63:0] inv_lines;
  logic inv_ack = 0;
  int checks = 0, fails = 0;

  p2v_reverse_map i_p2v_reverse_map (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] addr(input logic [11:0] pg, input int line);
    return {pg, 6'(line), 6'h04};
  endfunction

  task automatic fill(input logic [23:0] va, input logic [23:0] pa, input logic [1:0] pm);
    @(negedge clk);
    fill_valid = 1; fill_vaddr = va; fill_paddr = pa; fill_perm = pm;
    @(posedge clk); #1;
    fill_valid = 0;
  endtask

  task automatic probe(input logic [23:0] pa);
    @(negedge clk);
    coh_req = 1; coh_paddr = pa;
    @(posedge clk); #1;
    coh_req = 0;
  endtask

  task automatic clear(input logic [23:0] pa);
    @(negedge clk);
    clr_valid = 1; clr_paddr = pa;
    @(posedge clk); #1;
    clr_valid = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk(!res_valid && !coh_valid && !inv_valid && fill_ready, "R1 reset outputs",
        {res_valid, coh_valid, inv_valid, fill_ready}, 4'b0001);
    rst_n = 1;
    probe(addr(12'h010, 0));
    chk(coh_valid && !coh_hit, "R1 empty table", coh_hit, 0);

    for (int l = 0; l < 64; l++) begin
      fill(addr(12'h3A5, l), addr(12'h010, l), 2'd1);
      chk(res_valid && res_kind == (l == 0 ? 2'd0 : 2'd1), l == 0 ? "R2 new page" : "R3 line added",
          res_kind, l == 0 ? 0 : 1);
      chk(res_vaddr == addr(12'h3A5, l), "R3 vaddr passthrough", res_vaddr, addr(12'h3A5, l));
    end

    for (int l = 0; l < 64; l++) begin
      probe(addr(12'h010, l));
      chk(coh_valid && coh_hit && coh_vaddr == addr(12'h3A5, l), "R5 coherence hit",
          {coh_hit, coh_vaddr}, {1'b1, addr(12'h3A5, l)});
    end
    probe(addr(12'h020, 3));
    chk(coh_valid && !coh_hit, "R5 absent page filtered", coh_hit, 0);

    for (int l = 0; l < 64; l++) begin
      fill(addr(12'h7C1, l), addr(12'h010, l), 2'd3);
      chk(res_valid && res_kind == 2'd2 && res_vaddr == addr(12'h3A5, l) && res_perm == 2'd1,
          "R4 synonym redirect", {res_kind, res_perm, res_vaddr}, {2'd2, 2'd1, addr(12'h3A5, l)});
    end

    for (int l = 0; l < 64; l += 2) fill(addr(12'h100, l), addr(12'h011, l), 2'd2);
    for (int l = 0; l < 64; l++) begin
      probe(addr(12'h011, l));
      chk(coh_hit == (l % 2 == 0), "R5 line bit filter", coh_hit, (l % 2 == 0));
    end

    for (int k = 1; k <= 3; k++) begin
      fill(addr(12'h200 + 12'(k), k), addr({4'(k), 8'h10}, k), 2'd0);
      chk(res_kind == 2'd0 && !inv_valid && fill_ready, "R10 same set coexist",
          {inv_valid, res_kind}, 0);
    end
    for (int k = 1; k <= 3; k++) begin
      probe(addr({4'(k), 8'h10}, k));
      chk(coh_hit, "R10 ways resident", coh_hit, 1);
    end
    probe(addr(12'h010, 9));
    chk(coh_hit, "R10 first page resident", coh_hit, 1);

    fill(addr(12'h204, 4), addr(12'h410, 4), 2'd0);
    chk(res_valid && res_kind == 2'd0, "R6 eviction fill new", res_kind, 0);
    chk(inv_valid && inv_vpn == 12'h3A5 && inv_lines == '1, "R6 victim way0",
        {inv_vpn, inv_lines}, {12'h3A5, 64'hFFFF_FFFF_FFFF_FFFF});
    chk(!fill_ready, "R7 ready low", fill_ready, 0);
    fill(addr(12'h300, 0), addr(12'h0A0, 0), 2'd0);
    chk(!res_valid, "R7 blocked fill ignored", res_valid, 0);
    repeat (3) @(posedge clk);
    #1;
    chk(inv_valid && inv_vpn == 12'h3A5, "R6 request held", inv_vpn, 12'h3A5);
    @(negedge clk); inv_ack = 1;
    @(posedge clk); #1; inv_ack = 0;
    chk(!inv_valid && fill_ready, "R7 ack releases", {inv_valid, fill_ready}, 2'b01);
    probe(addr(12'h0A0, 0));
    chk(!coh_hit, "R7 ignored fill left no entry", coh_hit, 0);
    probe(addr(12'h010, 5));
    chk(!coh_hit, "R6 victim removed", coh_hit, 0);

    fill(addr(12'h205, 5), addr(12'h510, 5), 2'd0);
    chk(inv_valid && inv_vpn == 12'h201 && inv_lines == (64'd1 << 1), "R6 round robin way1",
        {inv_vpn, inv_lines}, {12'h201, 64'd2});
    @(negedge clk); inv_ack = 1;
    @(posedge clk); #1; inv_ack = 0;

    for (int l = 0; l < 64; l += 2) begin
      if (l == 30) begin
        @(negedge clk);
        clr_valid = 1; clr_paddr = addr(12'h011, l);
        fill_valid = 1; fill_vaddr = addr(12'h155, 1); fill_paddr = addr(12'h011, 1); fill_perm = 0;
        #1;
        chk(!fill_ready, "R9 clear blocks fill", fill_ready, 0);
        @(posedge clk); #1;
        clr_valid = 0; fill_valid = 0;
        chk(!res_valid, "R9 fill ignored", res_valid, 0);
      end else clear(addr(12'h011, l));
      probe(addr(12'h011, l));
      chk(!coh_hit, "R8 line cleared", coh_hit, 0);
    end
    probe(addr(12'h011, 1));
    chk(!coh_hit, "R9 ignored fill set no bit", coh_hit, 0);
    fill(addr(12'h155, 1), addr(12'h011, 1), 2'd3);
    chk(res_kind == 2'd0 && res_vaddr == addr(12'h155, 1), "R8 freed entry refilled new",
        {res_kind, res_vaddr}, {2'd0, addr(12'h155, 1)});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule